// File: doc/BRIEF.md
# Sync Presence Detector with Hysteresis

This block decides whether an external horizontal or composite sync signal is present. Once per video line a strobe arrives together with a flag saying whether a sync pulse was seen during that line. The block counts unbroken runs of matching lines. When a run reaches the programmed length, it flips a registered presence flag. The flag drives a sync-judgment output and chooses between free-running internal timing and locked external timing.

Two separate threshold codes give the transition hysteresis. One sets how many consecutive sync lines are needed before sync is declared present. The other sets how many consecutive lines without sync are needed before it is declared lost. Each code selects a power-of-two run length through one-hot bits. The acquisition run can be shortened to a single line, and loss detection can be switched off completely. The analog separator that produces the per-line indication is outside this block.

Top module: `sync_presence_detector`

## Requirements
- R1: While `rst_n` is low, the flag is low and the run count is cleared. A run that was partly counted before reset contributes nothing afterwards.
- R2: `sync_present` changes only on the clock edge that samples `line_strobe` high. Changes on `sync_seen` between strobes have no effect on it.
- R3: While the flag is low, `acq_code` bit 0, bit 1 or bit 2 set alone means 4, 8 or 16 consecutive strobes with `sync_seen` high. The flag rises on the edge of the last of those strobes and not earlier.
- R4: When `acq_code` is 000 and the flag is low, the first strobe with `sync_seen` high raises the flag.
- R5: While the flag is low, a strobe with `sync_seen` low restarts the acquisition run from zero.
- R6: While the flag is high, `loss_code` bit 0, 1, 2 or 3 set alone means 32, 64, 128 or 256 consecutive strobes with `sync_seen` low. The flag falls on the edge of the last of those strobes.
- R7: When `loss_code` is 0000, the flag stays high however many lines without sync arrive.
- R8: While the flag is high, a strobe with `sync_seen` high restarts the loss run from zero.
- R9: A code with more than one bit set behaves as if only its highest set bit were set.
- R10: Every flip of the flag starts the opposite run from zero. Lines counted toward acquisition never count toward loss, and the reverse holds too.
- R11: The run count never exceeds the largest loss threshold. If a threshold is lowered below the run already counted, the flip happens on the next matching strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_strobe | input | 1 | One-cycle pulse, once per line period |
| sync_seen | input | 1 | High when a sync pulse was found in the line being strobed |
| acq_code | input | ACQ_BITS | Absent-to-present run length select (one-hot, power of two from 4) |
| loss_code | input | LOSS_BITS | Present-to-absent run length select (one-hot, power of two from 32, zero disables) |
| sync_present | output | 1 | Registered judgment, high while sync is considered present |

## Verification
The checker assumes that `line_strobe` is a single-cycle pulse and that `sync_seen` is valid in the cycle where the strobe is high. It also assumes the threshold codes are steady around each strobe edge. The stimulus drives every input on the falling clock edge and keeps the strobe high for exactly one cycle with idle cycles between strobes. Threshold codes change only between strobes, and `sync_seen` is moved between strobes only to show that it is ignored there.

// File: rtl/syncdet_pkg.sv
package syncdet_pkg;

   // Judgment state held by the detector
   typedef enum logic {
      LINK_ABSENT  = 1'b0,
      LINK_PRESENT = 1'b1
   } link_state_e;

   // Longest run a one-hot code of the given shape can select
   function automatic int unsigned longest_run(input int unsigned base_log2,
                                               input int unsigned bits);
      return 32'd1 << (base_log2 + bits - 1);
   endfunction

endpackage

// File: rtl/syncdet_thr_decode.sv
module syncdet_thr_decode #(
   parameter int BITS      = 3,
   parameter int BASE_LOG2 = 2,
   parameter int CNT_W     = 9
) (
   input  logic [BITS-1:0]  code,
   output logic [CNT_W-1:0] limit,
   output logic             armed
);

   generate
      if (BITS < 1) begin : g_bits_check
         $error("syncdet_thr_decode: BITS must be at least 1");
      end
      if (BASE_LOG2 + BITS > CNT_W) begin : g_width_check
         $error("syncdet_thr_decode: CNT_W too narrow for the largest run");
      end
   endgenerate

   logic [CNT_W-1:0] weight [BITS];
   logic [BITS-1:0]  top_hot;

   // One weight per code bit; isolate the highest set bit
   for (genvar i = 0; i < BITS; i++) begin : g_bit
      assign weight[i] = CNT_W'(1) << (BASE_LOG2 + i);
      if (i == BITS - 1) begin : g_top
         assign top_hot[i] = code[i];
      end else begin : g_low
         assign top_hot[i] = code[i] & ~(|code[BITS-1:i+1]);
      end
   end

   always_comb begin
      limit = '0;
      for (int k = 0; k < BITS; k++) begin
         if (top_hot[k]) limit = limit | weight[k];
      end
   end

   assign armed = |code;

endmodule

// File: rtl/syncdet_run_tracker.sv
module syncdet_run_tracker #(
   parameter int CNT_W   = 9,
   parameter int RUN_MAX = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             match,
   input  logic             armed,
   input  logic [CNT_W-1:0] limit,
   output logic             hit,
   output logic [CNT_W-1:0] run_cnt
);

   generate
      if (RUN_MAX >= (1 << CNT_W)) begin : g_max_check
         $error("syncdet_run_tracker: RUN_MAX does not fit CNT_W");
      end
   endgenerate

   logic [CNT_W:0] next_len;

   assign next_len = {1'b0, run_cnt} + (CNT_W+1)'(1);
   assign hit      = strobe & match & armed & (next_len >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (strobe) begin
         if (!match || !armed || hit) begin
            run_cnt <= '0;
         end else if (run_cnt < CNT_W'(RUN_MAX)) begin
            run_cnt <= next_len[CNT_W-1:0];
         end
      end
   end

endmodule

// File: rtl/sync_presence_detector.sv
module sync_presence_detector
   import syncdet_pkg::*;
#(
   parameter int ACQ_BITS       = 3,
   parameter int ACQ_BASE_LOG2  = 2,
   parameter int LOSS_BITS      = 4,
   parameter int LOSS_BASE_LOG2 = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_strobe,
   input  logic                 sync_seen,
   input  logic [ACQ_BITS-1:0]  acq_code,
   input  logic [LOSS_BITS-1:0] loss_code,
   output logic                 sync_present
);

   localparam int ACQ_MAX  = int'(longest_run(ACQ_BASE_LOG2, ACQ_BITS));
   localparam int LOSS_MAX = int'(longest_run(LOSS_BASE_LOG2, LOSS_BITS));
   localparam int RUN_MAX  = (ACQ_MAX > LOSS_MAX) ? ACQ_MAX : LOSS_MAX;
   localparam int CNT_W    = $clog2(RUN_MAX + 1);

   generate
      if (ACQ_BITS < 1 || LOSS_BITS < 1) begin : g_code_check
         $error("sync_presence_detector: threshold codes need at least one bit");
      end
   endgenerate

   logic [CNT_W-1:0] acq_limit, loss_limit, acq_limit_eff, limit_sel;
   logic             acq_armed, loss_armed, armed_sel;
   logic             match, hit;
   logic [CNT_W-1:0] run_cnt;
   link_state_e      state;

   syncdet_thr_decode #(
      .BITS(ACQ_BITS), .BASE_LOG2(ACQ_BASE_LOG2), .CNT_W(CNT_W)
   ) u_acq_dec (
      .code(acq_code), .limit(acq_limit), .armed(acq_armed)
   );

   syncdet_thr_decode #(
      .BITS(LOSS_BITS), .BASE_LOG2(LOSS_BASE_LOG2), .CNT_W(CNT_W)
   ) u_loss_dec (
      .code(loss_code), .limit(loss_limit), .armed(loss_armed)
   );

   // A zero acquisition code means a single sync line is enough
   assign acq_limit_eff = acq_armed ? acq_limit : CNT_W'(1);

   always_comb begin
      if (state == LINK_PRESENT) begin
         match     = ~sync_seen;
         limit_sel = loss_limit;
         armed_sel = loss_armed;
      end else begin
         match     = sync_seen;
         limit_sel = acq_limit_eff;
         armed_sel = 1'b1;
      end
   end

   syncdet_run_tracker #(
      .CNT_W(CNT_W), .RUN_MAX(RUN_MAX)
   ) u_run (
      .clk(clk), .rst_n(rst_n), .strobe(line_strobe), .match(match),
      .armed(armed_sel), .limit(limit_sel), .hit(hit), .run_cnt(run_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LINK_ABSENT;
      end else if (hit) begin
         state <= (state == LINK_PRESENT) ? LINK_ABSENT : LINK_PRESENT;
      end
   end

   assign sync_present = (state == LINK_PRESENT);

endmodule

// File: rtl/sync_presence_checker.sv
module sync_presence_checker #(
   parameter int ACQ_BITS  = 3,
   parameter int LOSS_BITS = 4,
   parameter int CNT_W     = 9,
   parameter int RUN_MAX   = 256
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 line_strobe,
   input logic                 sync_seen,
   input logic [ACQ_BITS-1:0]  acq_code,
   input logic [LOSS_BITS-1:0] loss_code,
   input logic                 sync_present,
   input logic [CNT_W-1:0]     run_cnt
);

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!sync_present && run_cnt == '0));

   assert_hold_between_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !line_strobe |=> $stable(sync_present));

   assert_rise_on_sync_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_present) |-> $past(line_strobe && sync_seen));

   assert_zero_code_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_strobe && sync_seen && !sync_present && acq_code == '0) |=> sync_present);

   assert_gap_restarts_acq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (line_strobe && !sync_seen && !sync_present) |=> (run_cnt == '0));

   assert_fall_on_gap_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_present) |-> $past(line_strobe && !sync_seen));

   assert_loss_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_strobe && sync_present && loss_code == '0) |=> sync_present);

   assert_sync_restarts_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (line_strobe && sync_seen && sync_present) |=> (run_cnt == '0));

   assert_flip_clears_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_present != $past(sync_present)) |-> (run_cnt == '0));

   assert_run_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= CNT_W'(RUN_MAX));

endmodule

bind sync_presence_detector sync_presence_checker #(
   .ACQ_BITS(ACQ_BITS), .LOSS_BITS(LOSS_BITS), .CNT_W(CNT_W), .RUN_MAX(RUN_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .sync_seen(sync_seen),
   .acq_code(acq_code), .loss_code(loss_code), .sync_present(sync_present),
   .run_cnt(run_cnt)
);

// File: tb/sync_presence_detector_test.sv
module sync_presence_detector_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_strobe = 1'b0;
   logic       sync_seen = 1'b0;
   logic [2:0] acq_code = 3'b000;
   logic [3:0] loss_code = 4'b0000;
   logic       sync_present;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sync_presence_detector uut (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .sync_seen(sync_seen),
      .acq_code(acq_code), .loss_code(loss_code), .sync_present(sync_present)
   );

   // {acq[3], loss[4], seen, count[9], flag before last line, flag after}
   localparam int NV = 12;
   localparam logic [18:0] VEC [NV] = '{
      {3'b001, 4'b0001, 1'b1, 9'd4,   1'b0, 1'b1},  // R3 run of 4
      {3'b001, 4'b0001, 1'b0, 9'd32,  1'b1, 1'b0},  // R6 run of 32, R10
      {3'b010, 4'b0001, 1'b1, 9'd8,   1'b0, 1'b1},  // R3 run of 8
      {3'b010, 4'b0010, 1'b0, 9'd64,  1'b1, 1'b0},  // R6 run of 64
      {3'b100, 4'b0010, 1'b1, 9'd16,  1'b0, 1'b1},  // R3 run of 16
      {3'b100, 4'b0100, 1'b0, 9'd128, 1'b1, 1'b0},  // R6 run of 128
      {3'b000, 4'b0100, 1'b1, 9'd1,   1'b0, 1'b1},  // R4 zero code
      {3'b000, 4'b1000, 1'b0, 9'd256, 1'b1, 1'b0},  // R6 run of 256
      {3'b110, 4'b1000, 1'b1, 9'd16,  1'b0, 1'b1},  // R9 highest bit -> 16
      {3'b110, 4'b0011, 1'b0, 9'd64,  1'b1, 1'b0},  // R9 highest bit -> 64
      {3'b001, 4'b0000, 1'b1, 9'd4,   1'b0, 1'b1},  // R3 again
      {3'b001, 4'b0000, 1'b0, 9'd300, 1'b1, 1'b1}   // R7 loss disabled
   };

   task automatic chk(input string tag, input logic exp);
      checks++;
      if (sync_present !== exp) begin
         fails++;
         $display("FAIL %s: sync_present=%0b expected %0b", tag, sync_present, exp);
      end
   endtask

   task automatic line(input logic seen);
      @(negedge clk);
      sync_seen   = seen;
      line_strobe = 1'b1;
      @(negedge clk);
      line_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic lines(input logic seen, input int n);
      for (int i = 0; i < n; i++) line(seen);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      logic [2:0] a;
      logic [3:0] l;
      logic       s;
      logic [8:0] n;
      logic       eb, ea;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset state", 1'b0);

      for (int v = 0; v < NV; v++) begin
         {a, l, s, n, eb, ea} = VEC[v];
         acq_code  = a;
         loss_code = l;
         lines(s, int'(n) - 1);
         chk($sformatf("R3/R4/R6/R7/R9 vector %0d before last line", v), eb);
         line(s);
         chk($sformatf("R3/R4/R6/R7/R9 vector %0d after last line", v), ea);
      end

      // R2: sync_seen toggling without a strobe does nothing
      do_reset();
      acq_code  = 3'b000;
      loss_code = 4'b0001;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         sync_seen = i[0];
      end
      chk("R2 no strobe no change", 1'b0);
      line(1'b1);
      chk("R2 strobe applies", 1'b1);

      // R5: a missing line restarts acquisition
      do_reset();
      acq_code = 3'b001;
      lines(1'b1, 3);
      line(1'b0);
      lines(1'b1, 3);
      chk("R5 broken run not accepted", 1'b0);
      line(1'b1);
      chk("R5 fresh run of 4 accepted", 1'b1);

      // R8: a sync line restarts loss counting
      loss_code = 4'b0001;
      lines(1'b0, 31);
      line(1'b1);
      lines(1'b0, 31);
      chk("R8 broken loss run ignored", 1'b1);
      line(1'b0);
      chk("R8 fresh run of 32 drops", 1'b0);

      // R11: lowering the threshold below the counted run
      acq_code = 3'b100;
      lines(1'b1, 8);
      chk("R11 below 16 still absent", 1'b0);
      acq_code = 3'b001;
      line(1'b1);
      chk("R11 lowered limit flips at next line", 1'b1);

      // R10: acquisition lines do not count toward loss
      lines(1'b0, 31);
      chk("R10 loss run starts at zero", 1'b1);
      line(1'b0);
      chk("R10 loss after 32", 1'b0);

      // R1: reset discards a partial run and clears the flag
      lines(1'b1, 3);
      do_reset();
      chk("R1 flag low after reset", 1'b0);
      lines(1'b1, 3);
      chk("R1 partial run discarded", 1'b0);
      line(1'b1);
      chk("R1 new run completes", 1'b1);
      do_reset();
      chk("R1 reset clears present flag", 1'b0);

      summary();
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         summary();
         $finish;
      end
   end

endmodule